// File: doc/BRIEF.md
# Next-Line Instruction Stream Buffer

This block sits beside an instruction cache and handles that cache's misses. When the cache misses on block address A and the buffer has nothing useful, the block sends a demand read for A to the next memory level. It also queues a prefetch read for A+1. The demand data goes straight to the cache as a fill. The prefetched block stays in a one-entry stream buffer and is never written into the cache unprompted.

When a later miss names the block held in the buffer, the fill is served from the buffer with no demand read. The buffer then moves on to the next sequential block and prefetches it. If the buffered block is still in flight, the miss waits for that response and no duplicate read is sent. A miss that matches nothing flushes the buffer and starts a new sequence from the new address.

On the memory port, every request and response carries a source bit (0 = demand, 1 = prefetch) and the block address. A response is matched to its request by that pair. The cache array and its replacement policy live outside the block.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset the buffer holds no block: miss_ready is 1, fill_valid and mem_req_valid are 0, and the first miss (even to address 0) is served by a demand read with fill_from_buf = 0.
- R2: A miss that finds no matching buffer entry issues exactly one memory request with mem_req_pf = 0 for the miss address. Its fill carries that address and the returned data, with fill_from_buf = 0. A prefetch request (mem_req_pf = 1) for the next block address follows.
- R3: A miss whose address equals the buffered block, with that block's data present, is filled in the cycle after acceptance with fill_from_buf = 1 and the prefetched data. No demand request is sent.
- R4: After a fill served from the buffer for block B, the buffer tracks B+1 and issues a prefetch request for B+1.
- R5: A miss that does not match the buffered block discards the buffer. A later miss to the discarded block is served by a demand read.
- R6: A miss to the buffered block whose prefetch is still outstanding waits for that response and sends no second request for it. The fill then has fill_from_buf = 1.
- R7: While a demand request is waiting to be sent, any request on the memory port is a demand request (mem_req_pf = 0).
- R8: Block addresses wrap modulo 2^ADDR_W: the block after the all-ones address is address 0.
- R9: While the block is waiting on memory for a miss, miss_ready is 0. This covers both a demand read and an outstanding prefetch the miss matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_ready | output | 1 | Block can accept a miss |
| fill_valid | output | 1 | One-cycle fill pulse to the cache |
| fill_addr | output | ADDR_W | Block address of the fill |
| fill_data | output | DATA_W | Block contents of the fill |
| fill_from_buf | output | 1 | 1 if the fill came from the stream buffer |
| mem_req_valid | output | 1 | Read request to next level |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_addr | output | ADDR_W | Requested block address |
| mem_req_pf | output | 1 | Request source: 0 demand, 1 prefetch |
| mem_rsp_valid | input | 1 | Response from next level |
| mem_rsp_addr | input | ADDR_W | Block address of the response |
| mem_rsp_pf | input | 1 | Source bit echoed from the request |
| mem_rsp_data | input | DATA_W | Returned block contents |

## Verification
Directed runs of strictly ascending addresses show the buffer chaining from one hit to the next. A jump followed by a return to the abandoned block shows that a flush really discards the entry. Stretching prefetch latency so that a miss lands on a block still in flight separates waiting from re-requesting, and a run through the all-ones address exposes wrap errors. Random mixes of sequential steps, repeats and jumps, under random memory stalls, are checked against a bench model of which misses should hit the buffer. That model also gives the number of demand reads each miss should cost.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DEMAND = 2'd1,
    ST_WAITPF = 2'd2
  } sb_state_e;

  localparam logic SRC_DEMAND = 1'b0;
  localparam logic SRC_PF     = 1'b1;
endpackage

// File: rtl/sbuf_entry.sv
module sbuf_entry #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_addr,
  input  logic              advance,
  input  logic              issue_ack,
  input  logic              rsp_valid,
  input  logic              rsp_pf,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              ent_valid,
  output logic              ent_pending,
  output logic              ent_issued,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [DATA_W-1:0] ent_data,
  output logic              look_ready,
  output logic              look_waiting,
  output logic              rsp_take
);
  function automatic logic [ADDR_W-1:0] succ(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic look_match;
  assign look_match   = ent_valid && (ent_addr == look_addr);
  assign look_ready   = look_match && !ent_pending;
  assign look_waiting = look_match && ent_pending;
  assign rsp_take     = rsp_valid && rsp_pf && ent_valid && ent_pending &&
                        ent_issued && (rsp_addr == ent_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid   <= 1'b0;
      ent_pending <= 1'b0;
      ent_issued  <= 1'b0;
      ent_addr    <= '0;
      ent_data    <= '0;
    end else if (restart) begin
      ent_valid   <= 1'b1;
      ent_pending <= 1'b1;
      ent_issued  <= 1'b0;
      ent_addr    <= succ(restart_addr);
    end else if (advance) begin
      ent_pending <= 1'b1;
      ent_issued  <= 1'b0;
      ent_addr    <= succ(ent_addr);
    end else begin
      if (issue_ack) ent_issued <= 1'b1;
      if (rsp_take) begin
        ent_pending <= 1'b0;
        ent_data    <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/sbuf_req_arb.sv
module sbuf_req_arb #(
  parameter int ADDR_W = 16
) (
  input  logic              dem_valid,
  input  logic [ADDR_W-1:0] dem_addr,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_pf,
  output logic              dem_ack,
  output logic              pf_ack
);
  import sbuf_pkg::*;

  assign mem_valid = dem_valid || pf_valid;
  assign mem_pf    = dem_valid ? SRC_DEMAND : SRC_PF;
  assign mem_addr  = dem_valid ? dem_addr : pf_addr;
  assign dem_ack   = dem_valid && mem_ready;
  assign pf_ack    = !dem_valid && pf_valid && mem_ready;
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_from_buf,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_pf,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic              mem_rsp_pf,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  import sbuf_pkg::*;

  sb_state_e         state;
  logic              dem_pend;
  logic [ADDR_W-1:0] dem_addr;
  logic [ADDR_W-1:0] wait_addr;

  logic              ent_valid, ent_pending, ent_issued;
  logic [ADDR_W-1:0] ent_addr;
  logic [DATA_W-1:0] ent_data;
  logic              look_ready, look_waiting, rsp_take;
  logic [ADDR_W-1:0] look_addr;
  logic              dem_ack, pf_ack, pf_want;

  // named internal events, also watched by the checker
  logic miss_fire, ev_buf_hit, ev_buf_wait, ev_miss_restart;
  logic ev_wait_done, ev_dem_rsp, ev_fill;

  assign miss_ready      = (state == ST_IDLE);
  assign miss_fire       = miss_valid && miss_ready;
  assign look_addr       = (state == ST_IDLE) ? miss_addr : wait_addr;
  assign ev_buf_hit      = miss_fire && look_ready;
  assign ev_buf_wait     = miss_fire && look_waiting;
  assign ev_miss_restart = miss_fire && !look_ready && !look_waiting;
  assign ev_wait_done    = (state == ST_WAITPF) && look_ready;
  assign ev_dem_rsp      = (state == ST_DEMAND) && mem_rsp_valid &&
                           (mem_rsp_pf == SRC_DEMAND) && (mem_rsp_addr == dem_addr);
  assign ev_fill         = ev_buf_hit || ev_wait_done || ev_dem_rsp;
  assign pf_want         = ent_valid && ent_pending && !ent_issued;

  sbuf_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) entry_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (ev_miss_restart),
    .restart_addr (miss_addr),
    .advance      (ev_buf_hit || ev_wait_done),
    .issue_ack    (pf_ack),
    .rsp_valid    (mem_rsp_valid),
    .rsp_pf       (mem_rsp_pf),
    .rsp_addr     (mem_rsp_addr),
    .rsp_data     (mem_rsp_data),
    .look_addr    (look_addr),
    .ent_valid    (ent_valid),
    .ent_pending  (ent_pending),
    .ent_issued   (ent_issued),
    .ent_addr     (ent_addr),
    .ent_data     (ent_data),
    .look_ready   (look_ready),
    .look_waiting (look_waiting),
    .rsp_take     (rsp_take)
  );

  sbuf_req_arb #(.ADDR_W(ADDR_W)) arb_i (
    .dem_valid (dem_pend),
    .dem_addr  (dem_addr),
    .pf_valid  (pf_want),
    .pf_addr   (ent_addr),
    .mem_ready (mem_req_ready),
    .mem_valid (mem_req_valid),
    .mem_addr  (mem_req_addr),
    .mem_pf    (mem_req_pf),
    .dem_ack   (dem_ack),
    .pf_ack    (pf_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dem_pend  <= 1'b0;
      dem_addr  <= '0;
      wait_addr <= '0;
    end else begin
      if (dem_ack) dem_pend <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ev_miss_restart) begin
            state    <= ST_DEMAND;
            dem_pend <= 1'b1;
            dem_addr <= miss_addr;
          end else if (ev_buf_wait) begin
            state     <= ST_WAITPF;
            wait_addr <= miss_addr;
          end
        end
        ST_DEMAND: if (ev_dem_rsp)   state <= ST_IDLE;
        ST_WAITPF: if (ev_wait_done) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid    <= 1'b0;
      fill_addr     <= '0;
      fill_data     <= '0;
      fill_from_buf <= 1'b0;
    end else begin
      fill_valid <= ev_fill;
      if (ev_fill) begin
        fill_from_buf <= !ev_dem_rsp;
        fill_data     <= ev_dem_rsp ? mem_rsp_data : ent_data;
        fill_addr     <= ev_dem_rsp ? dem_addr :
                         (ev_wait_done ? wait_addr : miss_addr);
      end
    end
  end
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              miss_ready,
  input logic              mem_req_valid,
  input logic              mem_req_pf,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              fill_valid,
  input logic              fill_from_buf,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              ev_buf_hit,
  input logic              ev_miss_restart,
  input logic              dem_pend,
  input logic              ent_valid,
  input logic              ent_pending,
  input logic              ent_issued,
  input logic [ADDR_W-1:0] ent_addr
);
  a_r7_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_pend && mem_req_valid) |-> !mem_req_pf);

  a_r6_pf_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_pf) |->
      (ent_valid && ent_pending && !ent_issued && mem_req_addr == ent_addr));

  a_r2_restart_next: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss_restart |=>
      (ent_valid && ent_pending && ent_addr == ($past(miss_addr) + 1'b1)));

  a_r3_hit_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_hit |=> (fill_valid && fill_from_buf && fill_addr == $past(miss_addr) && !dem_pend));

  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_hit |=> (ent_pending && ent_addr == ($past(miss_addr) + 1'b1)));

  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dem_pend |-> !miss_ready);
endmodule

bind stream_prefetcher sbuf_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .miss_addr       (miss_addr),
  .miss_ready      (miss_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_pf      (mem_req_pf),
  .mem_req_addr    (mem_req_addr),
  .fill_valid      (fill_valid),
  .fill_from_buf   (fill_from_buf),
  .fill_addr       (fill_addr),
  .ev_buf_hit      (ev_buf_hit),
  .ev_miss_restart (ev_miss_restart),
  .dem_pend        (dem_pend),
  .ent_valid       (ent_valid),
  .ent_pending     (ent_pending),
  .ent_issued      (ent_issued),
  .ent_addr        (ent_addr)
);

// File: tb/stream_prefetcher_tb_top.sv
`timescale 1ns/100ps
module stream_prefetcher_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic          miss_ready;
  logic          fill_valid, fill_from_buf;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic          mem_req_valid, mem_req_pf;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_rsp_addr = '0;
  logic          mem_rsp_pf = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  stream_prefetcher #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_from_buf(fill_from_buf),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_pf(mem_req_pf),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr),
    .mem_rsp_pf(mem_rsp_pf), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // memory model state
  logic [AW-1:0] q_addr[$];
  logic          q_pf[$];
  int            q_due[$];
  int            pf_extra = 0;
  int            dem_seen = 0;
  int            tgt_pf_seen = 0;
  logic [AW-1:0] tgt_addr = '0;
  logic [AW-1:0] last_pf = '0;
  bit            dem_wait = 0;

  // bench model of the buffer
  bit            m_valid = 0;
  logic [AW-1:0] m_addr = '0;

  function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    logic [AW:0] w;
    w = {1'b0, a} + 1;
    return w[AW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    bit r;
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
    end else begin
      r = ($urandom_range(0, 3) != 0);
      mem_req_ready = r;
      if (mem_req_valid && r) begin
        q_addr.push_back(mem_req_addr);
        q_pf.push_back(mem_req_pf);
        q_due.push_back(cyc + 2 + int'($urandom_range(0, 4)) + (mem_req_pf ? pf_extra : 0));
        if (!mem_req_pf) begin
          dem_seen++;
          dem_wait = 0;
        end else begin
          last_pf = mem_req_addr;
          if (mem_req_addr == tgt_addr) tgt_pf_seen++;
          if (dem_wait) chk(0, "R7 prefetch sent ahead of waiting demand", 1, 0);
        end
      end
      if (q_addr.size() > 0 && q_due[0] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_addr  = q_addr.pop_front();
        mem_rsp_pf    = q_pf.pop_front();
        mem_rsp_data  = mdata(mem_rsp_addr);
        void'(q_due.pop_front());
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_miss(input logic [AW-1:0] a, input string req);
    bit exp_buf;
    bit got;
    exp_buf = m_valid && (a == m_addr);
    m_valid = 1;
    m_addr  = nxt(a);
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(posedge clk);
    dem_seen = 0;
    if (!exp_buf) dem_wait = 1;
    @(negedge clk);
    miss_valid = 1'b0;
    if (!exp_buf) chk(miss_ready == 1'b0, "R9 miss_ready while busy", miss_ready, 0);
    got = 0;
    for (int t = 0; t < 400; t++) begin
      if (fill_valid) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, {req, " fill seen"}, got, 1);
    if (got) begin
      chk(fill_addr == a, {req, " fill_addr"}, fill_addr, a);
      chk(fill_data == mdata(a), {req, " fill_data"}, fill_data, mdata(a));
      chk(fill_from_buf == exp_buf, {req, " fill_from_buf"}, fill_from_buf, exp_buf);
      chk(dem_seen == (exp_buf ? 0 : 1), {req, " demand count"}, dem_seen, exp_buf ? 0 : 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(miss_ready == 1'b1, "R1 miss_ready after reset", miss_ready, 1);
    chk(fill_valid == 1'b0, "R1 fill_valid after reset", fill_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", mem_req_valid, 0);
    do_miss(16'h0000, "R1 first miss demand");
    // R2 then R3/R4 chain
    do_miss(16'h0040, "R2 new miss");
    do_miss(16'h0041, "R3 buffer hit");
    repeat (12) @(negedge clk);
    chk(last_pf == 16'h0042, "R4 next prefetch", last_pf, 16'h0042);
    do_miss(16'h0042, "R4 chained hit");
    // R5 flush
    do_miss(16'h0100, "R5 setup");
    do_miss(16'h0200, "R5 jump");
    do_miss(16'h0101, "R5 discarded block");
    // R6 miss on pending prefetch
    tgt_addr = 16'h0301;
    tgt_pf_seen = 0;
    pf_extra = 40;
    do_miss(16'h0300, "R6 setup");
    do_miss(16'h0301, "R6 wait on pending");
    chk(tgt_pf_seen == 1, "R6 single prefetch", tgt_pf_seen, 1);
    pf_extra = 0;
    // R8 wrap
    do_miss(16'hFFFF, "R8 top block");
    do_miss(16'h0000, "R8 wrapped hit");
    // random mix (R2 R3 R5 R7)
    a = 16'h1000;
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom_range(0, 7));
      if (sel < 4) a = nxt(a);
      else if (sel < 6) a = 16'($urandom_range(0, 65535));
      else a = a;
      if ($urandom_range(0, 9) == 0) pf_extra = int'($urandom_range(0, 20));
      else pf_extra = 0;
      do_miss(a, "R3 random mix");
    end
    repeat (20) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule